// File: doc/BRIEF.md
# BCH Bit-Offset Corrector

This block finishes the repair of a 512-byte sector after an 8-error BCH decoder has run. The sector sits in a local byte-wide buffer. Its 13 stored check bytes follow the data at addresses 512 to 524. The decoder supplies an error count and a 104-bit vector that holds up to eight 13-bit bit positions. The vector arrives in three 32-bit words plus an extra top byte, so some positions span two words. After a start pulse, the block unpacks the positions and flips each addressed data bit with a read-modify-write through the single buffer port. It then reports how many bits it flipped.

A count above eight means the decoder gave up. The usual cause is a freshly erased sector, whose all-ones check bytes do not match the code of all-ones data. In this case the block counts zero bits over the data and check bytes together and stops as soon as the total passes eight. A total of eight or less marks the sector as erased: the block rewrites every data byte to 0xFF and reports zero corrections. A larger total raises the uncorrectable flag and leaves the buffer untouched.

Top module: `bch_bitfix`

## Requirements
- R1: After reset, busy, done, fixed_cnt and uncorrectable are 0, and the buffer port is idle (mem_rd = mem_wr = 0).
- R2: A start pulse is accepted only while the block is idle and dec_ready is 1. A start with dec_ready = 0 leaves busy and done low and changes no buffer byte.
- R3: Position k (k = 0..7) is bits [13k+12:13k] of the 104-bit vector {ecc_top, ecc_w2, ecc_w1, ecc_w0}. Bit 0 of ecc_w0 is vector bit 0. This puts position 2 across ecc_w0 and ecc_w1, position 4 across ecc_w1 and ecc_w2, and position 7 across ecc_w2 and ecc_top.
- R4: An err_count of 0 gives done one cycle after acceptance, with fixed_cnt = 0, uncorrectable = 0 and no buffer write.
- R5: For an err_count N from 1 to 8, only positions 0..N-1 are used, in order. A position p below 4096 inverts bit p[2:0] of byte p >> 3. Repeated positions invert again.
- R6: A position of 4096 or more points into the check bytes. It is skipped: nothing is written and it is not counted.
- R7: After a correction run, fixed_cnt equals the number of bits inverted and uncorrectable is 0.
- R8: For an err_count of 9 to 15, if the zero-bit total over buffer bytes 0..524 is at most 8, bytes 0..511 become 0xFF, bytes 512..524 keep their values, fixed_cnt = 0 and uncorrectable = 0.
- R9: For an err_count of 9 to 15 with more than 8 zero bits, uncorrectable = 1, fixed_cnt = 0 and the buffer is unchanged.
- R10: done is a one-cycle pulse. It comes after the last buffer write of the run. busy stays high from acceptance through done. fixed_cnt and uncorrectable hold until the next accepted start.
- R11: The buffer port never reads and writes in the same cycle, and it writes only to addresses below 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse for one sector |
| dec_ready | input | 1 | Decoder result valid |
| err_count | input | 4 | Decoder error count (0..15) |
| ecc_w0 | input | 32 | Vector bits 31:0 |
| ecc_w1 | input | 32 | Vector bits 63:32 |
| ecc_w2 | input | 32 | Vector bits 95:64 |
| ecc_top | input | 8 | Vector bits 103:96 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| fixed_cnt | output | 4 | Bits inverted in the last run |
| uncorrectable | output | 1 | Last sector could not be repaired |
| mem_rd | output | 1 | Buffer read; data returns on mem_rdata one cycle later |
| mem_wr | output | 1 | Buffer byte write |
| mem_addr | output | 10 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data |

## Verification
Directed position sets target the three positions that span word boundaries, the last data bit 4095, and the first and last check-area positions. These cases separate a wrong unpack slice from a wrong range test. A run with a count below the number of valid positions shows whether unused vector slots leak into the result. A repeated position shows whether the read-modify-write reads back its own earlier write. Erased-sector images with exactly eight and exactly nine zeros, some of them in the check bytes, pin the threshold and the scan range. Random buffer images with random positions and counts then compare every byte against a bench model.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FIX, ST_FIXWR, ST_SCAN, ST_FILL, ST_DONE
  } fix_state_t;

  // number of cleared bits in one byte
  function automatic logic [3:0] zero_bits(input logic [7:0] b);
    logic [3:0] n;
    n = 4'd0;
    for (int i = 0; i < 8; i++) n = n + {3'd0, ~b[i]};
    return n;
  endfunction

  // single-bit flip mask for a bit position within a byte
  function automatic logic [7:0] bit_mask(input logic [2:0] pos);
    return 8'h01 << pos;
  endfunction
endpackage

// File: rtl/bchfix_unpack.sv
module bchfix_unpack #(
  parameter int NUM   = 8,
  parameter int OFS_W = 13,
  localparam int VEC_W = NUM * OFS_W
) (
  input  logic [VEC_W-1:0]           vec,
  output logic [NUM-1:0][OFS_W-1:0]  ofs
);
  for (genvar g = 0; g < NUM; g++) begin : g_slice
    assign ofs[g] = vec[g*OFS_W +: OFS_W];
  end
endmodule

// File: rtl/bchfix_zscan.sv
module bchfix_zscan
  import bchfix_pkg::*;
#(
  parameter int LIMIT = 8,
  localparam int TW = $clog2(2*LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc_en,
  input  logic [7:0]    byte_in,
  output logic [TW-1:0] total,
  output logic          over
);
  assign over = (total > TW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                total <= '0;
    else if (clr)              total <= '0;
    else if (acc_en && !over)  total <= total + TW'(zero_bits(byte_in));
  end
endmodule

// File: rtl/bch_bitfix.sv
module bch_bitfix
  import bchfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_BYTES    = 13,
  parameter int MAX_ERR      = 8,
  parameter int OFS_W        = 13,
  parameter int CNT_W        = 4,
  parameter int WORD_W       = 32,
  localparam int AW          = $clog2(SECTOR_BYTES + ECC_BYTES),
  localparam int VEC_W       = MAX_ERR * OFS_W,
  localparam int TOP_W       = VEC_W - 3*WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dec_ready,
  input  logic [CNT_W-1:0]  err_count,
  input  logic [WORD_W-1:0] ecc_w0,
  input  logic [WORD_W-1:0] ecc_w1,
  input  logic [WORD_W-1:0] ecc_w2,
  input  logic [TOP_W-1:0]  ecc_top,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  fixed_cnt,
  output logic              uncorrectable,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int TOTAL     = SECTOR_BYTES + ECC_BYTES;
  localparam int DATA_BITS = SECTOR_BYTES * 8;
  localparam int PW        = AW + 1;
  localparam int SW        = $clog2(MAX_ERR);
  localparam int TW        = $clog2(2*MAX_ERR + 1);

  fix_state_t                 state;
  logic [VEC_W-1:0]           vec_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [CNT_W-1:0]           idx;
  logic [PW-1:0]              ptr;
  logic [AW-1:0]              hold_addr;
  logic [7:0]                 hold_mask;
  logic [CNT_W-1:0]           fixed_q;
  logic                       fail_q;
  logic                       pend;
  logic [MAX_ERR-1:0][OFS_W-1:0] ofs;
  logic [OFS_W-1:0]           cur_ofs;
  logic [TW-1:0]              ztotal;
  logic                       zover;

  // named events used by the checker
  logic accept, fix_more, in_data, fix_rd, fix_wr, scan_rd, fill_wr;

  bchfix_unpack #(.NUM(MAX_ERR), .OFS_W(OFS_W)) u_unpack (.vec(vec_q), .ofs(ofs));

  bchfix_zscan #(.LIMIT(MAX_ERR)) u_zscan (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .acc_en(pend && state == ST_SCAN), .byte_in(mem_rdata),
    .total(ztotal), .over(zover)
  );

  assign cur_ofs  = ofs[idx[SW-1:0]];
  assign accept   = (state == ST_IDLE) && start && dec_ready;
  assign fix_more = (idx < cnt_q);
  assign in_data  = (cur_ofs < OFS_W'(DATA_BITS));
  assign fix_rd   = (state == ST_FIX) && fix_more && in_data;
  assign fix_wr   = (state == ST_FIXWR);
  assign scan_rd  = (state == ST_SCAN) && (ptr < PW'(TOTAL)) && !zover;
  assign fill_wr  = (state == ST_FILL);

  assign mem_rd = fix_rd | scan_rd;
  assign mem_wr = fix_wr | fill_wr;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = 8'h00;
    case (state)
      ST_FIX:   mem_addr = AW'(cur_ofs >> 3);
      ST_FIXWR: begin mem_addr = hold_addr; mem_wdata = mem_rdata ^ hold_mask; end
      ST_SCAN:  mem_addr = ptr[AW-1:0];
      ST_FILL:  begin mem_addr = ptr[AW-1:0]; mem_wdata = 8'hFF; end
      default:  mem_addr = '0;
    endcase
  end

  assign busy          = (state != ST_IDLE);
  assign done          = (state == ST_DONE);
  assign fixed_cnt     = fixed_q;
  assign uncorrectable = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      vec_q     <= '0;
      cnt_q     <= '0;
      idx       <= '0;
      ptr       <= '0;
      hold_addr <= '0;
      hold_mask <= '0;
      fixed_q   <= '0;
      fail_q    <= 1'b0;
      pend      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          vec_q   <= {ecc_top, ecc_w2, ecc_w1, ecc_w0};
          cnt_q   <= err_count;
          idx     <= '0;
          ptr     <= '0;
          pend    <= 1'b0;
          fixed_q <= '0;
          fail_q  <= 1'b0;
          if (err_count == '0)                    state <= ST_DONE;
          else if (err_count > CNT_W'(MAX_ERR))   state <= ST_SCAN;
          else                                    state <= ST_FIX;
        end
        ST_FIX: begin
          if (!fix_more) state <= ST_DONE;
          else if (in_data) begin
            hold_addr <= AW'(cur_ofs >> 3);
            hold_mask <= bit_mask(cur_ofs[2:0]);
            state     <= ST_FIXWR;
          end else idx <= idx + 1'b1;
        end
        ST_FIXWR: begin
          fixed_q <= fixed_q + 1'b1;
          idx     <= idx + 1'b1;
          state   <= ST_FIX;
        end
        ST_SCAN: begin
          pend <= scan_rd;
          if (scan_rd) ptr <= ptr + 1'b1;
          if (zover) begin
            fail_q <= 1'b1;
            state  <= ST_DONE;
          end else if (ptr == PW'(TOTAL) && !pend) begin
            ptr   <= '0;
            state <= ST_FILL;
          end
        end
        ST_FILL: begin
          ptr <= ptr + 1'b1;
          if (ptr == PW'(SECTOR_BYTES - 1)) state <= ST_DONE;
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bchfix_chk.sv
module bchfix_chk #(
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_ERR      = 8,
  parameter int CNT_W        = 4,
  parameter int AW           = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             dec_ready,
  input logic [CNT_W-1:0] err_count,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] fixed_cnt,
  input logic             uncorrectable,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [AW-1:0]    mem_addr,
  input logic [7:0]       mem_wdata,
  input logic             fix_wr,
  input logic             fill_wr
);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_port_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_wr_region_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr < AW'(SECTOR_BYTES)));

  assert_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !dec_ready) |=> !busy);

  assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && dec_ready && err_count == '0) |=>
      (done && fixed_cnt == '0 && !uncorrectable));

  assert_rmw_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fix_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fixed_cnt <= CNT_W'(MAX_ERR)));

  assert_fill_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wr |-> (mem_wdata == 8'hFF));

  assert_fail_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && uncorrectable) |-> (fixed_cnt == '0));
endmodule

bind bch_bitfix bchfix_chk #(
  .SECTOR_BYTES(SECTOR_BYTES), .MAX_ERR(MAX_ERR), .CNT_W(CNT_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dec_ready(dec_ready),
  .err_count(err_count), .busy(busy), .done(done), .fixed_cnt(fixed_cnt),
  .uncorrectable(uncorrectable), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .fix_wr(fix_wr), .fill_wr(fill_wr)
);

// File: tb/sim_bch_bitfix.sv
module sim_bch_bitfix;
  localparam int NB = 525;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dec_ready = 1'b0;
  logic [3:0]  err_count = '0;
  logic [31:0] ecc_w0 = '0, ecc_w1 = '0, ecc_w2 = '0;
  logic [7:0]  ecc_top = '0;
  logic        busy, done, uncorrectable, mem_rd, mem_wr;
  logic [3:0]  fixed_cnt;
  logic [9:0]  mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  mem  [NB];
  logic [7:0]  expm [NB];
  logic [12:0] tofs [8];
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  bch_bitfix u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_ready(dec_ready),
    .err_count(err_count), .ecc_w0(ecc_w0), .ecc_w1(ecc_w1), .ecc_w2(ecc_w2),
    .ecc_top(ecc_top), .busy(busy), .done(done), .fixed_cnt(fixed_cnt),
    .uncorrectable(uncorrectable), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int zeros_in(input logic [7:0] b);
    int z = 0;
    for (int i = 0; i < 8; i++) if (b[i] == 1'b0) z++;
    return z;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic compare_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < NB; i++)
      if (mem[i] !== expm[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, req, $sformatf("buffer mismatches (first at %0d)", first), bad, 0);
  endtask

  // run one sector: tofs[] and cnt give the decoder result
  task automatic run_case(input int cnt, input string req);
    logic [103:0] v;
    int exp_n = 0, z = 0, waited = 0;
    bit exp_fail = 0, seen = 0;
    for (int k = 0; k < 8; k++) v[k*13 +: 13] = tofs[k];
    for (int i = 0; i < NB; i++) expm[i] = mem[i];
    if (cnt >= 1 && cnt <= 8) begin
      for (int k = 0; k < cnt; k++)
        if (tofs[k] < 13'd4096) begin
          expm[tofs[k] / 8][tofs[k] % 8] = ~expm[tofs[k] / 8][tofs[k] % 8];
          exp_n++;
        end
    end else if (cnt > 8) begin
      for (int i = 0; i < NB; i++) z += zeros_in(mem[i]);
      if (z <= 8) for (int i = 0; i < 512; i++) expm[i] = 8'hFF;
      else exp_fail = 1;
    end
    @(negedge clk);
    ecc_w0 = v[31:0]; ecc_w1 = v[63:32]; ecc_w2 = v[95:64]; ecc_top = v[103:96];
    err_count = 4'(cnt); dec_ready = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen && waited < 3000) begin
      if (done) seen = 1; else begin @(negedge clk); waited++; end
    end
    chk(seen, req, "done seen", int'(seen), 1);
    chk(fixed_cnt == 4'(exp_n), req, "fixed_cnt", int'(fixed_cnt), exp_n);
    chk(uncorrectable == exp_fail, req, "uncorrectable", int'(uncorrectable), int'(exp_fail));
    compare_mem(req);
    @(negedge clk);
    chk(!done && !busy, "R10", "done pulse width", int'(done), 0);
  endtask

  task automatic fill_random();
    for (int i = 0; i < NB; i++) mem[i] = 8'($urandom);
  endtask

  task automatic fill_erased();
    for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish");
    nfail++;
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    fill_random();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done after reset", int'(busy | done), 0);
    chk(fixed_cnt == 0 && !uncorrectable, "R1", "results after reset", int'(fixed_cnt), 0);
    chk(!mem_rd && !mem_wr, "R1", "port idle after reset", int'(mem_rd | mem_wr), 0);

    // R4 zero count
    for (int k = 0; k < 8; k++) tofs[k] = 13'(k * 37);
    run_case(0, "R4");

    // R5 single flip at bit 0
    tofs[0] = 13'd0;
    run_case(1, "R5");

    // R3 straddling positions plus last data bit, full count of eight
    tofs[0] = 13'd4095; tofs[1] = 13'd1; tofs[2] = 13'd4093; tofs[3] = 13'd2050;
    tofs[4] = 13'd3071; tofs[5] = 13'd7;  tofs[6] = 13'd2222; tofs[7] = 13'd4094;
    run_case(8, "R3");

    // R6 check-area positions skipped, not counted
    tofs[0] = 13'd4096; tofs[1] = 13'd100; tofs[2] = 13'd8191; tofs[3] = 13'd4100;
    run_case(4, "R6");

    // R5 only the first N used: slots 3..7 hold valid positions
    for (int k = 0; k < 8; k++) tofs[k] = 13'(500 + k * 300);
    run_case(3, "R5");

    // R7 repeated position inverts twice
    tofs[0] = 13'd777; tofs[1] = 13'd777; tofs[2] = 13'd778;
    run_case(3, "R7");

    // R8 erased sector with exactly eight zeros, some in check bytes
    fill_erased();
    mem[3] = 8'hFE; mem[100] = 8'hF0; mem[520] = 8'hFC; mem[511] = 8'h7F;
    run_case(9, "R8");

    // R8 clean erased sector, count 15
    fill_erased();
    run_case(15, "R8");

    // R9 nine zeros: uncorrectable, untouched
    fill_erased();
    mem[3] = 8'hFE; mem[100] = 8'hF0; mem[520] = 8'hFC; mem[511] = 8'h7F; mem[524] = 8'hBF;
    run_case(12, "R9");

    // R9 random data with overflowed decoder
    fill_random();
    run_case(10, "R9");

    // R2 start while decoder not ready
    begin
      bit any = 0;
      for (int i = 0; i < NB; i++) expm[i] = mem[i];
      @(negedge clk);
      err_count = 4'd2; tofs[0] = 13'd5; ecc_w0 = 32'd5; dec_ready = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 20; c++) begin
        if (busy || done) any = 1;
        @(negedge clk);
      end
      chk(!any, "R2", "busy/done after unready start", int'(any), 0);
      compare_mem("R2");
    end

    // R5 random sectors and positions
    for (int n = 0; n < 40; n++) begin
      fill_random();
      for (int k = 0; k < 8; k++) tofs[k] = 13'($urandom % 5200);
      run_case(1 + int'($urandom % 8), "R5");
    end

    summary();
  end
endmodule